// File: doc/BRIEF.md
# Synthetic-Sample ADC Register Model

This block stands in for an analog-to-digital converter in a system where only the programming interface matters. It keeps the converter's full set of 32-bit control, status, timing, threshold, sequence, injected-offset and data words behind a single-cycle register bus. Nothing is sampled from an analog pin. Each conversion result comes from a deterministic accumulator that advances by a fixed step. The result is clipped to the resolution that software has chosen and can be left-aligned.

The bus has separate write and read address ports, so a write and a read can land in the same cycle. The block accepts every strobe, so it is always ready, and it never applies back-pressure. A read response is valid for exactly one cycle, one clock after the strobe, and the requester must take it in that cycle because it cannot be held. Because a read of the data word has side effects, each read strobe lasts one cycle and acts exactly once. The interrupt output is held low.

Byte offsets that other logic decodes: status 0x00, control A 0x04, control B 0x08, sample-time words 0x0C and 0x10, injected offsets 0x14 + 4n (n = 0..3), high threshold 0x24, low threshold 0x28, sequence words 0x2C, 0x30 and 0x34, injected sequence 0x38, injected data 0x3C + 4n, and conversion data 0x4C.

Top module: `adc_regmodel`

## Requirements
- R1: After reset the high-threshold word (0x24) reads 0x00000FFF and every other mapped word reads 0. The bus outputs are low while reset is held.
- R2: Control A, both sample-time words, both thresholds, the three sequence words and the injected-sequence word store all 32 written bits and read them back unchanged.
- R3: A write to status (0x00) leaves the old contents ANDed with the written bits 5:0, so set bits can only be cleared and never set. All other status bits become 0.
- R4: A read of control B (0x08) returns only bits 27:0 of the stored word. Bits 31:28 read as 0.
- R5: A read of the data word (0x4C) returns 0 and leaves the accumulator unchanged unless control B bit 0 (enable) and bit 30 (go) are both set.
- R6: A data read with enable and go both set adds 7 to the accumulator. It then masks the result to the width chosen by control A bits 25:24 (0: 12 bits, 1: 10, 2: 8, 3: 6) and stores the masked value as the new accumulator. The accumulator starts at 0.
- R7: When control B bit 11 is set, the sampling read returns (new accumulator << 1) & 0xFFF0. When the bit is clear, it returns the new accumulator itself.
- R8: A sampling read clears the go bit, so the next data read returns 0 until go is written again. If a control B write lands in the same cycle, the written value is kept whole.
- R9: Each injected-offset word keeps only bits 11:0 of a write. A read of injected data n returns the stored data word minus offset n, modulo 2^32.
- R10: An access at byte offset 0x100 or above, or to any offset not listed, reads 0 and changes no state. This holds even when its low 8 bits match a mapped word.
- R11: rd_valid is high exactly in the cycle after each rd_en, and rd_data carries the response in that cycle. Otherwise rd_valid and rd_data are 0, and irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Registered read response |
| rd_valid | output | 1 | Response valid, one cycle after rd_en |
| irq | output | 1 | Interrupt, held at 0 |

## Verification
Two functions can collide in one cycle: the automatic clearing of go by a sampling data read, and a software write to control B. The bench provokes this by issuing a data read on the read port and a control B write on the write port in the same cycle. It does this once with go set in the written value and once with go clear. Each case is judged by the following data read: it must return the next accumulator sample when the written go survives, and 0 when the written value cleared go. A control B alias written above 0x100 is also followed by a data read, which confirms that the remote write never reached the control word.

// File: rtl/adc_rm_pkg.sv
package adc_rm_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned NUM_INJ  = 4;
  localparam int unsigned OFS_BITS = 12;
  localparam int unsigned STEP     = 7;

  // byte offsets within the local window
  localparam logic [7:0] OFF_STAT  = 8'h00;
  localparam logic [7:0] OFF_CTLA  = 8'h04;
  localparam logic [7:0] OFF_CTLB  = 8'h08;
  localparam logic [7:0] OFF_SMPH  = 8'h0C;
  localparam logic [7:0] OFF_SMPL  = 8'h10;
  localparam logic [7:0] OFF_IOFS0 = 8'h14;
  localparam logic [7:0] OFF_THRH  = 8'h24;
  localparam logic [7:0] OFF_THRL  = 8'h28;
  localparam logic [7:0] OFF_SEQ0  = 8'h2C;
  localparam logic [7:0] OFF_SEQ1  = 8'h30;
  localparam logic [7:0] OFF_SEQ2  = 8'h34;
  localparam logic [7:0] OFF_ISEQ  = 8'h38;
  localparam logic [7:0] OFF_IDAT0 = 8'h3C;
  localparam logic [7:0] OFF_DATA  = 8'h4C;

  // plain full-width storage words
  localparam int unsigned NUM_PLAIN = 9;
  localparam int unsigned IDX_CTLA  = 0;
  localparam int unsigned IDX_THRH  = 3;
  localparam logic [7:0] PLAIN_OFF [NUM_PLAIN] = '{
    OFF_CTLA, OFF_SMPH, OFF_SMPL, OFF_THRH, OFF_THRL,
    OFF_SEQ0, OFF_SEQ1, OFF_SEQ2, OFF_ISEQ
  };

  localparam logic [DW-1:0] THRH_RST    = 32'h0000_0FFF;
  localparam logic [DW-1:0] CTLB_RDMASK = 32'h0FFF_FFFF;
  localparam logic [DW-1:0] ALIGN_MASK  = 32'h0000_FFF0;
  localparam int unsigned   STAT_WBITS  = 6;

  // control B bit positions
  localparam int unsigned CTLB_EN    = 0;
  localparam int unsigned CTLB_ALIGN = 11;
  localparam int unsigned CTLB_GO    = 30;
  // control A resolution field low bit
  localparam int unsigned CTLA_RES_LO = 24;

  typedef enum logic [1:0] {
    RES_12 = 2'd0,
    RES_10 = 2'd1,
    RES_8  = 2'd2,
    RES_6  = 2'd3
  } res_e;

  function automatic logic [DW-1:0] res_mask(input res_e r);
    int unsigned w;
    w = 12 - 2 * int'(r);
    return DW'((64'd1 << w) - 64'd1);
  endfunction
endpackage

// File: rtl/adc_rm_word_reg.sv
module adc_rm_word_reg #(
  parameter int unsigned    DW  = 32,
  parameter logic [DW-1:0]  RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= wdata;
  end

  a_r2_keeps_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == $past(wdata));
endmodule

// File: rtl/adc_rm_sample_gen.sv
module adc_rm_sample_gen
  import adc_rm_pkg::*;
#(
  parameter int unsigned   W     = 32,
  parameter int unsigned   INC   = 7,
  parameter logic [W-1:0]  AMASK = 32'h0000_FFF0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  res_e         res,
  input  logic         align,
  output logic [W-1:0] sample
);
  logic [W-1:0] acc_q, acc_nxt;

  always_comb begin
    acc_nxt = (acc_q + W'(INC)) & W'(res_mask(res));
    sample  = align ? ((acc_nxt << 1) & AMASK) : acc_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= acc_nxt;
  end

  // R5: no sampling read, no movement
  a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc_q));
  // R6: every sample differs from the previous and fits in 12 bits
  a_r6_acc_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> acc_q != $past(acc_q));
  a_r6_acc_width: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (acc_q >> 12) == '0);
endmodule

// File: rtl/adc_rm_inj_bank.sv
module adc_rm_inj_bank #(
  parameter int unsigned NUM = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned OB  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM-1:0]         ofs_we,
  input  logic [NUM-1:0]         dat_we,
  input  logic [DW-1:0]          wdata,
  output logic [NUM-1:0][DW-1:0] ofs_rd,
  output logic [NUM-1:0][DW-1:0] dat_rd
);
  for (genvar g = 0; g < NUM; g++) begin : g_ch
    logic [OB-1:0] ofs_q;
    logic [DW-1:0] dat_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ofs_q <= '0;
        dat_q <= '0;
      end else begin
        if (ofs_we[g]) ofs_q <= wdata[OB-1:0];
        if (dat_we[g]) dat_q <= wdata;
      end
    end

    assign ofs_rd[g] = {{(DW-OB){1'b0}}, ofs_q};
    assign dat_rd[g] = dat_q - ofs_rd[g];

    // R9: an offset write keeps only its low bits
    a_r9_ofs_low: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_we[g] |=> ofs_rd[g] == {{(DW-OB){1'b0}}, $past(wdata[OB-1:0])});
  end
endmodule

// File: rtl/adc_regmodel.sv
module adc_regmodel
  import adc_rm_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              irq
);
  localparam int unsigned LOC_W = 8;

  logic          wr_local, rd_local;
  logic [7:0]    wr_off, rd_off;
  logic          wr_ok, rd_ok;

  assign wr_local = (wr_addr >> LOC_W) == '0;
  assign rd_local = (rd_addr >> LOC_W) == '0;
  assign wr_off   = wr_addr[7:0];
  assign rd_off   = rd_addr[7:0];
  assign wr_ok    = wr_en && wr_local;
  assign rd_ok    = rd_en && rd_local;

  // plain storage words
  logic [NUM_PLAIN-1:0]         plain_we;
  logic [NUM_PLAIN-1:0][DW-1:0] plain_q;

  for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
    assign plain_we[i] = wr_ok && (wr_off == PLAIN_OFF[i]);
    adc_rm_word_reg #(
      .DW  (DW),
      .RST ((i == IDX_THRH) ? THRH_RST : '0)
    ) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (plain_we[i]),
      .wdata (wr_data),
      .q     (plain_q[i])
    );
  end

  // status: clear-only
  logic          stat_we;
  logic [DW-1:0] stat_q;
  assign stat_we = wr_ok && (wr_off == OFF_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_we) stat_q <= stat_q & {{(DW-STAT_WBITS){1'b0}}, wr_data[STAT_WBITS-1:0]};
  end

  // control B with go auto-clear; a write wins
  logic          ctlb_we, fire;
  logic [DW-1:0] ctlb_q;
  assign ctlb_we = wr_ok && (wr_off == OFF_CTLB);
  assign fire    = rd_ok && (rd_off == OFF_DATA) && ctlb_q[CTLB_EN] && ctlb_q[CTLB_GO];

  always_ff @(posedge clk) begin
    if (!rst_n)       ctlb_q <= '0;
    else if (ctlb_we) ctlb_q <= wr_data;
    else if (fire)    ctlb_q[CTLB_GO] <= 1'b0;
  end

  // synthetic sample source
  logic [DW-1:0] sample;
  adc_rm_sample_gen #(
    .W     (DW),
    .INC   (STEP),
    .AMASK (ALIGN_MASK)
  ) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (fire),
    .res    (res_e'(plain_q[IDX_CTLA][CTLA_RES_LO +: 2])),
    .align  (ctlb_q[CTLB_ALIGN]),
    .sample (sample)
  );

  // injected offsets and data
  logic [NUM_INJ-1:0]         ofs_we, dat_we;
  logic [NUM_INJ-1:0][DW-1:0] ofs_rd, dat_rd;

  for (genvar k = 0; k < NUM_INJ; k++) begin : g_injdec
    assign ofs_we[k] = wr_ok && (wr_off == 8'(OFF_IOFS0 + 4 * k));
    assign dat_we[k] = wr_ok && (wr_off == 8'(OFF_IDAT0 + 4 * k));
  end

  adc_rm_inj_bank #(
    .NUM (NUM_INJ),
    .DW  (DW),
    .OB  (OFS_BITS)
  ) u_inj (
    .clk    (clk),
    .rst_n  (rst_n),
    .ofs_we (ofs_we),
    .dat_we (dat_we),
    .wdata  (wr_data),
    .ofs_rd (ofs_rd),
    .dat_rd (dat_rd)
  );

  // read mux
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rd_local) begin
      if (rd_off == OFF_STAT) rd_mux = stat_q;
      if (rd_off == OFF_CTLB) rd_mux = ctlb_q & CTLB_RDMASK;
      if (rd_off == OFF_DATA) rd_mux = fire ? sample : '0;
      for (int i = 0; i < NUM_PLAIN; i++)
        if (rd_off == PLAIN_OFF[i]) rd_mux = plain_q[i];
      for (int k = 0; k < NUM_INJ; k++) begin
        if (rd_off == 8'(OFF_IOFS0 + 4 * k)) rd_mux = ofs_rd[k];
        if (rd_off == 8'(OFF_IDAT0 + 4 * k)) rd_mux = dat_rd[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_en ? rd_mux : '0;
      rd_valid <= rd_en;
    end
  end

  assign irq = 1'b0;

  // R11: response timing
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && rd_data == '0));
  // R8: go clears after a sample unless control B is written
  a_r8_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctlb_we) |=> !ctlb_q[CTLB_GO]);
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctlb_we |=> ctlb_q == $past(wr_data));
  // R3: status never gains bits
  a_r3_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> (stat_q & ~$past(stat_q)) == '0);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> $stable(stat_q));
  // R10: remote writes leave the control word alone
  a_r10_remote_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_local && !fire) |=> $stable(ctlb_q));
endmodule

// File: tb/tb_adc_regmodel.sv
module tb_adc_regmodel;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wr_data;
  logic [31:0]   rd_data;
  logic          rd_valid, irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] acc_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_regmodel #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // monitor: pops the scoreboard on each response
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected response", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R11 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  task automatic do_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic do_both(input logic [AW-1:0] wa, input logic [31:0] d,
                         input logic [AW-1:0] ra, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = wa; wr_data = d;
    rd_en = 1'b1; rd_addr = ra;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  // reference sample from the requirement text
  function automatic logic [31:0] next_sample(input int res, input bit align);
    logic [31:0] m;
    m = (32'd1 << (12 - 2 * res)) - 32'd1;
    acc_m = (acc_m + 32'd7) & m;
    return align ? ((acc_m << 1) & 32'h0000_FFF0) : acc_m;
  endfunction

  localparam logic [AW-1:0] A_DATA = 12'h04C;
  localparam logic [AW-1:0] A_CTLB = 12'h008;
  localparam logic [AW-1:0] A_CTLA = 12'h004;

  initial begin
    logic [31:0] v;
    logic [31:0] ofs [4];
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
    check("R1 rd_data in reset", rd_data, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R1 reset values
    for (int o = 0; o <= 'h4C; o += 4)
      do_rd(AW'(o), (o == 'h24) ? 32'h0000_0FFF : 32'd0, $sformatf("R1 reset @%h", o));

    // R2 full-width storage
    foreach (adc_rm_pkg::PLAIN_OFF[i]) begin
      v = {adc_rm_pkg::PLAIN_OFF[i], ~adc_rm_pkg::PLAIN_OFF[i], 8'hC3, 8'(i * 17)};
      do_wr(AW'(adc_rm_pkg::PLAIN_OFF[i]), v);
      do_rd(AW'(adc_rm_pkg::PLAIN_OFF[i]), v, "R2 readback");
    end
    do_wr(12'h028, 32'hFFFF_FFFF);
    do_rd(12'h028, 32'hFFFF_FFFF, "R2 all ones");

    // R4 control B read mask
    do_wr(A_CTLB, 32'hFFFF_FFFF);
    do_rd(A_CTLB, 32'h0FFF_FFFF, "R4 top nibble hidden");
    do_wr(A_CTLB, 32'h4000_0801);
    do_rd(A_CTLB, 32'h0000_0801, "R4 go hidden");
    do_wr(A_CTLB, 32'h0);

    // R3 status clear-only
    do_wr(12'h000, 32'h0000_003F);
    do_rd(12'h000, 32'h0, "R3 cannot set low bits");
    do_wr(12'h000, 32'hFFFF_FFFF);
    do_rd(12'h000, 32'h0, "R3 cannot set any bit");

    // R5 gating
    do_rd(A_DATA, 32'h0, "R5 idle");
    do_wr(A_CTLB, 32'h0000_0001);
    do_rd(A_DATA, 32'h0, "R5 enable only");
    do_wr(A_CTLB, 32'h4000_0000);
    do_rd(A_DATA, 32'h0, "R5 go only");

    // R6 12-bit, R8 go clears
    do_wr(A_CTLA, 32'h0);
    do_wr(A_CTLB, 32'h4000_0001);
    do_rd(A_DATA, next_sample(0, 0), "R6 first sample");
    do_rd(A_DATA, 32'h0, "R8 go cleared");
    do_wr(A_CTLB, 32'h4000_0001);
    do_rd(A_DATA, next_sample(0, 0), "R5 R6 held across gated read");

    // R6 6-bit with wrap
    do_wr(A_CTLA, 32'h0300_0000);
    for (int n = 0; n < 10; n++) begin
      do_wr(A_CTLB, 32'h4000_0001);
      do_rd(A_DATA, next_sample(3, 0), "R6 six-bit wrap");
    end
    do_wr(A_CTLA, 32'h0100_0000);
    do_wr(A_CTLB, 32'h4000_0001);
    do_rd(A_DATA, next_sample(1, 0), "R6 ten-bit");
    do_wr(A_CTLA, 32'h0200_0000);
    do_wr(A_CTLB, 32'h4000_0001);
    do_rd(A_DATA, next_sample(2, 0), "R6 eight-bit");

    // R7 alignment
    do_wr(A_CTLA, 32'h0);
    for (int n = 0; n < 3; n++) begin
      do_wr(A_CTLB, 32'h4000_0801);
      do_rd(A_DATA, next_sample(0, 1), "R7 left aligned");
    end
    do_wr(A_CTLA, 32'h0300_0000);
    do_wr(A_CTLB, 32'h4000_0801);
    do_rd(A_DATA, next_sample(3, 1), "R7 aligned six-bit");

    // R8 same-cycle collision
    do_wr(A_CTLA, 32'h0);
    do_wr(A_CTLB, 32'h4000_0001);
    do_both(A_CTLB, 32'h4000_0001, A_DATA, next_sample(0, 0), "R8 collide sample");
    do_rd(A_DATA, next_sample(0, 0), "R8 written go survives");
    do_wr(A_CTLB, 32'h4000_0001);
    do_both(A_CTLB, 32'h0000_0001, A_DATA, next_sample(0, 0), "R8 collide sample 2");
    do_rd(A_DATA, 32'h0, "R8 written clear kept");

    // R9 injected offsets and data
    for (int k = 0; k < 4; k++) begin
      ofs[k] = 32'(k * 'h123 + 'h10);
      do_wr(AW'('h14 + 4 * k), 32'hABCD_E000 | ofs[k]);
      do_rd(AW'('h14 + 4 * k), ofs[k], "R9 offset low bits");
      v = 32'h0001_0000 + 32'(k * 'h1111);
      do_wr(AW'('h3C + 4 * k), v);
      do_rd(AW'('h3C + 4 * k), v - ofs[k], "R9 data minus offset");
    end
    do_wr(12'h03C, 32'd5);
    do_rd(12'h03C, 32'hFFFF_FFF5, "R9 subtract wraps");

    // R10 remote and unmapped
    do_wr(12'h024, 32'h0000_0AAA);
    do_wr(12'h124, 32'h1234_5678);
    do_rd(12'h024, 32'h0000_0AAA, "R10 alias write ignored");
    do_rd(12'h124, 32'h0, "R10 remote read zero");
    do_rd(12'h100, 32'h0, "R10 base read zero");
    do_wr(12'h050, 32'hDEAD_BEEF);
    do_rd(12'h050, 32'h0, "R10 unmapped read zero");
    do_wr(A_CTLB, 32'h0000_0001);
    do_wr(12'h108, 32'h4000_0001);
    do_rd(A_DATA, 32'h0, "R10 remote control write ignored");

    // R11 drain and interrupt
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 all responses seen", 32'(exp_q.size()), 32'd0);
    check("R11 irq low", {31'd0, irq}, 32'd0);
    summary();
    $finish;
  end
endmodule